// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer on a small 32-bit register bus. Software loads a 20-bit tick count and sets a two-bit mode field to arm the timer. A prescaler divides the system clock into ticks of about 15 µs, and the armed counter steps down once per tick. If software does not reload the count in time, the counter expires. The block then drives a fixed-length full-reset request to the chip's reset network and records the event in a status register.

Every register write must carry the key byte 0x5A in bits 31:24. A write without it changes nothing. The status register holds a set of software-written flag bits, which boot code uses to choose a partition or to detect a halt request. These bits survive the reset that the watchdog itself causes, and only the power-on reset input clears them.

Top module: `wdog_rstctl`

## Requirements
- R1: A write changes a register only when wr_data[31:24] is 0x5A. A write with any other top byte leaves the mode field, the count and the status register unchanged.
- R2: The count register is at offset 0x24. A keyed write loads wr_data[19:0] into the counter and discards bits 23:20. A read returns the remaining ticks in bits 19:0 and zeros above them.
- R3: The control register is at offset 0x1C. A keyed write stores wr_data[5:4] as the mode field, and a read returns that field in bits 5:4 with all other bits zero. Mode 2'b10 means armed, so bit 5 reads 1 while the timer runs.
- R4: The counter decrements only while the mode is 2'b10, by one every TICK_DIV clocks. The first decrement comes TICK_DIV clocks after the arming or reload write. A count write restarts the tick phase, so regular reloads keep the timer from expiring.
- R5: An armed count of N expires on its Nth tick, TICK_DIV*N clocks after arming. From the next cycle, rst_req is high for exactly 16 clocks. Status bit 5 is set, the mode field clears to 2'b00, and the count reads 0.
- R6: The status register is at offset 0x20. A keyed write replaces bits 0, 2, 4, 6, 8 and 10 (mask 0x555) and leaves every other bit alone. Bit 5 is set only by an expiry and reads back in place.
- R7: sys_rst clears the mode field, the counter, the prescaler and the read register, but keeps the status register and any reset pulse already running. por clears everything, including status.
- R8: Read data is registered: it appears the cycle after rd_en and holds until the next read. Bits 31:24 always read 0, and offsets other than 0x1C, 0x20 and 0x24 read 0.
- R9: A keyed write of 0x102 to the control register clears the mode field. The counter then stays at its current value.
- R10: After por, all three registers read 0 and rst_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous active-high power-on reset; clears all state |
| sys_rst | input | 1 | Synchronous active-high chip reset; status register retained |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; bits 31:24 carry the key |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rst_req | output | 1 | Full-reset request pulse |

## Verification
The bench attacks the expiry instant. A design that decrements one tick early or late, or that keeps counting after a disarm, puts the reset pulse on the wrong cycle, and the per-clock model comparison catches it there. Writes with a wrong key are sent to each register. A design that checked only part of the key byte would arm the timer, load a count or set flags that then show up in later reads. The bench also checks that the status flags survive sys_rst but not por, that unwritable status bits stay clear when ones are written to them, that a mode of 2'b11 does not count, and that periodic reloads prevent the pulse. A design that merged the two reset inputs, or that let an unkeyed write through, would read back the wrong status or count.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned VIEW_W = 24;

    localparam logic [7:0]  WR_KEY   = 8'h5A;
    localparam logic [31:0] OFS_CTRL = 32'h1C;
    localparam logic [31:0] OFS_STAT = 32'h20;
    localparam logic [31:0] OFS_CNT  = 32'h24;

    localparam logic [1:0]  MODE_ARM     = 2'b10;
    localparam int unsigned STAT_W       = 11;
    localparam logic [STAT_W-1:0] STAT_SW_MASK = 11'h555;
    localparam int unsigned STAT_EXP_BIT = 5;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CNT
    } reg_sel_e;

    typedef struct packed {
        logic              ctrl_we;
        logic              stat_we;
        logic              cnt_we;
        logic [VIEW_W-1:0] payload;
    } wr_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_CNT:  s = SEL_CNT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic key_ok(input logic [REG_W-1:0] d);
        return d[REG_W-1 -: 8] == WR_KEY;
    endfunction

    function automatic logic [STAT_W-1:0] merge_status(
        input logic [STAT_W-1:0] cur,
        input logic [STAT_W-1:0] wr
    );
        return (cur & ~STAT_SW_MASK) | (wr & STAT_SW_MASK);
    endfunction

endpackage

// File: rtl/wdr_bus.sv
module wdr_bus
    import wdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [VIEW_W-1:0] ctrl_view,
    input  logic [VIEW_W-1:0] stat_view,
    input  logic [VIEW_W-1:0] cnt_view,
    output wr_cmd_t           cmd,
    output logic [REG_W-1:0]  rd_data
);

    reg_sel_e          sel;
    logic              accept;
    logic [VIEW_W-1:0] rd_nxt;
    logic [VIEW_W-1:0] rd_q;

    always_comb begin
        sel         = decode_addr(32'(addr));
        accept      = wr_en && key_ok(wr_data) && !hold;
        cmd.ctrl_we = accept && (sel == SEL_CTRL);
        cmd.stat_we = accept && (sel == SEL_STAT);
        cmd.cnt_we  = accept && (sel == SEL_CNT);
        cmd.payload = wr_data[VIEW_W-1:0];
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rd_nxt = ctrl_view;
            SEL_STAT: rd_nxt = stat_view;
            SEL_CNT:  rd_nxt = cnt_view;
            default:  rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_nxt;
        end
    end

    assign rd_data = {{(REG_W-VIEW_W){1'b0}}, rd_q};

endmodule

// File: rtl/wdr_prescale.sv
module wdr_prescale #(
    parameter int unsigned TICK_DIV = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);

    localparam int unsigned PRE_W = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] phase;
    logic             at_last;

    assign at_last = (phase == PRE_LAST);
    assign tick    = !rst && run && !clr && at_last;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            phase <= '0;
        end else if (at_last) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic near_end;

    assign near_end = (cnt <= ONE);
    assign expire   = tick && near_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= (cnt == '0) ? '0 : cnt - ONE;
        end
    end

endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] FULL = PW'(PULSE_LEN);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= FULL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign active = (remain != '0);

endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
    import wdr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 20,
    parameter int unsigned TICK_DIV  = 1500,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sys_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              rst_req
);

    localparam int unsigned MODE_LSB = 4;

    logic              core_rst;
    wr_cmd_t           cmd;
    logic [1:0]        mode;
    logic [STAT_W-1:0] status;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    logic              tick;
    logic              expire;
    logic              cnt_load;
    logic [VIEW_W-1:0] ctrl_view;
    logic [VIEW_W-1:0] stat_view;
    logic [VIEW_W-1:0] cnt_view;
    logic              unused_payload;

    assign core_rst       = por || sys_rst;
    assign armed          = (mode == MODE_ARM);
    assign cnt_load       = cmd.cnt_we;
    assign unused_payload = ^cmd.payload[VIEW_W-1:CNT_W];

    assign ctrl_view = VIEW_W'({mode, {MODE_LSB{1'b0}}});
    assign stat_view = VIEW_W'(status);
    assign cnt_view  = VIEW_W'(cnt);

    wdr_bus #(
        .ADDR_W (ADDR_W)
    ) bus_i (
        .clk       (clk),
        .rst       (core_rst),
        .hold      (sys_rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .ctrl_view (ctrl_view),
        .stat_view (stat_view),
        .cnt_view  (cnt_view),
        .cmd       (cmd),
        .rd_data   (rd_data)
    );

    wdr_prescale #(
        .TICK_DIV (TICK_DIV)
    ) pre_i (
        .clk  (clk),
        .rst  (core_rst),
        .run  (armed),
        .clr  (cnt_load),
        .tick (tick)
    );

    wdr_countdown #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst      (core_rst),
        .load     (cnt_load),
        .load_val (cmd.payload[CNT_W-1:0]),
        .tick     (tick),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdr_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) pulse_i (
        .clk    (clk),
        .rst    (por),
        .fire   (expire),
        .active (rst_req)
    );

    // mode field: expiry overrides a same-cycle control write
    always_ff @(posedge clk) begin
        if (core_rst || expire) begin
            mode <= 2'b00;
        end else if (cmd.ctrl_we) begin
            mode <= cmd.payload[MODE_LSB +: 2];
        end
    end

    // status survives sys_rst; only power-on clears it
    always_ff @(posedge clk) begin
        if (por) begin
            status <= '0;
        end else begin
            if (cmd.stat_we) begin
                status <= merge_status(status, cmd.payload[STAT_W-1:0]);
            end
            if (expire) begin
                status[STAT_EXP_BIT] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdr_chk.sv
module wdr_chk
    import wdr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 20,
    parameter int unsigned PULSE_LEN = 16
) (
    input logic              clk,
    input logic              por,
    input logic              sys_rst,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              rst_req,
    input logic [1:0]        mode,
    input logic [STAT_W-1:0] status,
    input logic [CNT_W-1:0]  cnt,
    input logic              expire,
    input logic              cnt_load
);

    localparam int unsigned HW = $clog2(PULSE_LEN + 2);

    logic [HW-1:0] high_run;

    always_ff @(posedge clk) begin
        if (por || expire) begin
            high_run <= '0;
        end else if (rst_req) begin
            high_run <= high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    // R1
    bad_key_ignored_chk: assert property (@(posedge clk) disable iff (por)
        (wr_en && wr_data[31:24] != WR_KEY && !expire)
        |=> ($stable(status) && ($stable(mode) || $past(sys_rst))));

    // R4
    idle_frozen_chk: assert property (@(posedge clk) disable iff (por)
        (mode != MODE_ARM && !cnt_load && !sys_rst) |=> $stable(cnt));

    // R5
    expiry_effect_chk: assert property (@(posedge clk) disable iff (por)
        expire |=> (rst_req && status[STAT_EXP_BIT] && mode == 2'b00 && cnt == '0));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (por)
        $fell(rst_req) |-> (high_run == HW'(PULSE_LEN)));

    // R8
    rd_top_zero_chk: assert property (@(posedge clk) disable iff (por)
        rd_data[31:24] == 8'h00);

    // R7
    por_clears_chk: assert property (@(posedge clk) disable iff (sys_rst)
        por |=> (status == '0 && mode == 2'b00 && !rst_req));

endmodule

bind wdog_rstctl wdr_chk #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
) chk_i (
    .clk      (clk),
    .por      (por),
    .sys_rst  (sys_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rst_req  (rst_req),
    .mode     (mode),
    .status   (status),
    .cnt      (cnt),
    .expire   (expire),
    .cnt_load (cnt_load)
);

// File: tb/wdog_rstctl_tb_top.sv
module wdog_rstctl_tb_top;

    localparam int DIV = 4;
    localparam int PL  = 16;
    localparam int CW  = 20;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        sys_rst = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rst_req;

    int    vec_cnt = 0;
    int    miss_cnt = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    wdog_rstctl #(
        .ADDR_W    (8),
        .CNT_W     (CW),
        .TICK_DIV  (DIV),
        .PULSE_LEN (PL)
    ) dut_i (
        .clk     (clk),
        .por     (por),
        .sys_rst (sys_rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    // behavioural reference model
    int          m_mode, m_cnt, m_pre, m_stat, m_pulse;
    logic [31:0] m_rd;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C:   return 32'(m_mode << 4);
            8'h20:   return 32'(m_stat);
            8'h24:   return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit kw, cw, tk, ex;
        if (por) begin
            m_mode = 0; m_cnt = 0; m_pre = 0; m_stat = 0; m_pulse = 0; m_rd = '0;
        end else begin
            kw = wr_en && (wr_data[31:24] == 8'h5A) && !sys_rst;
            cw = kw && addr == 8'h24;
            if (sys_rst) m_rd = '0;
            else if (rd_en) m_rd = model_read(addr);
            tk = !sys_rst && m_mode == 2 && !cw && m_pre == DIV - 1;
            ex = tk && m_cnt <= 1;
            if (ex) m_pulse = PL;
            else if (m_pulse > 0) m_pulse--;
            if (kw && addr == 8'h20) m_stat = (m_stat & ~32'h555) | (int'(wr_data) & 32'h555);
            if (ex) m_stat = m_stat | 32'h20;
            if (sys_rst || m_mode != 2 || cw) m_pre = 0;
            else if (m_pre == DIV - 1) m_pre = 0;
            else m_pre++;
            if (sys_rst) m_cnt = 0;
            else if (cw) m_cnt = int'(wr_data) & 32'hFFFFF;
            else if (tk) m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
            if (sys_rst || ex) m_mode = 0;
            else if (kw && addr == 8'h1C) m_mode = (int'(wr_data) >> 4) & 3;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vec_cnt++;
            if (rd_data !== m_rd || rst_req !== (m_pulse != 0)) begin
                miss_cnt++;
                $display("FAIL %s model: rd_data=%h rst_req=%b expected rd_data=%h rst_req=%b",
                         cur_req, rd_data, rst_req, m_rd, (m_pulse != 0));
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        miss_cnt++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin : stim
        int n;
        int h;
        // R10: reset state
        idle(3);
        por = 1'b0;
        rd_chk(8'h1C, 32'h0, "R10");
        rd_chk(8'h20, 32'h0, "R10");
        rd_chk(8'h24, 32'h0, "R10");
        chk(32'(rst_req), 32'h0, "R10");

        // R2: count load and field width
        cur_req = "R2";
        wr(8'h24, 32'h5A7F_FFFF);
        rd_chk(8'h24, 32'h000F_FFFF, "R2");
        wr(8'h24, 32'h5A00_0005);
        rd_chk(8'h24, 32'h0000_0005, "R2");

        // R1: wrong key ignored on every register
        cur_req = "R1";
        wr(8'h1C, 32'hA500_0020);
        rd_chk(8'h1C, 32'h0, "R1");
        wr(8'h24, 32'h0000_0009);
        rd_chk(8'h24, 32'h5, "R1");
        wr(8'h20, 32'h5B00_0555);
        rd_chk(8'h20, 32'h0, "R1");

        // R4: unarmed modes do not count
        cur_req = "R4";
        idle(20);
        rd_chk(8'h24, 32'h5, "R4");
        wr(8'h1C, 32'h5A00_0030);
        rd_chk(8'h1C, 32'h30, "R3");
        idle(20);
        rd_chk(8'h24, 32'h5, "R4");

        // R3/R5: arm and expire after DIV*N clocks
        cur_req = "R5";
        wr(8'h1C, 32'h5A00_0020);
        rd_chk(8'h1C, 32'h20, "R3");
        n = 2;
        while (!rst_req && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(32'(n), 32'(DIV * 5), "R5");
        h = 0;
        while (rst_req && h < 100) begin
            h++;
            @(negedge clk);
        end
        chk(32'(h), 32'(PL), "R5");
        rd_chk(8'h1C, 32'h0, "R5");
        rd_chk(8'h24, 32'h0, "R5");
        rd_chk(8'h20, 32'h20, "R5");

        // R6: status flag bits
        cur_req = "R6";
        wr(8'h20, 32'h5A00_0555);
        rd_chk(8'h20, 32'h575, "R6");
        wr(8'h20, 32'h5A00_0000);
        rd_chk(8'h20, 32'h020, "R6");
        wr(8'h20, 32'h5A00_0FFF);
        rd_chk(8'h20, 32'h575, "R6");

        // R7: sys_rst keeps status, clears the rest
        cur_req = "R7";
        wr(8'h24, 32'h5A00_0007);
        wr(8'h1C, 32'h5A00_0020);
        @(negedge clk);
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        rd_chk(8'h1C, 32'h0, "R7");
        rd_chk(8'h24, 32'h0, "R7");
        rd_chk(8'h20, 32'h575, "R7");
        idle(40);
        chk(32'(rst_req), 32'h0, "R7");

        // R9: disarm freezes the count
        cur_req = "R9";
        wr(8'h24, 32'h5A00_0064);
        wr(8'h1C, 32'h5A00_0020);
        idle(29);
        wr(8'h1C, 32'h5A00_0102);
        idle(40);
        rd_chk(8'h24, 32'd93, "R9");
        rd_chk(8'h1C, 32'h0, "R9");

        // R4: periodic reloads prevent expiry
        cur_req = "R4";
        wr(8'h24, 32'h5A00_0003);
        wr(8'h1C, 32'h5A00_0020);
        for (int k = 0; k < 6; k++) begin
            idle(6);
            wr(8'h24, 32'h5A00_0003);
        end
        chk(32'(rst_req), 32'h0, "R4");
        wr(8'h1C, 32'h5A00_0102);

        // R8: unmapped offsets and read hold
        cur_req = "R8";
        rd_chk(8'h28, 32'h0, "R8");
        rd_chk(8'h00, 32'h0, "R8");
        rd_chk(8'h20, 32'h575, "R8");
        idle(3);
        chk(rd_data, 32'h575, "R8");

        // R7: power-on clears status
        cur_req = "R7";
        @(negedge clk);
        por = 1'b1;
        idle(2);
        por = 1'b0;
        rd_chk(8'h20, 32'h0, "R7");
        rd_chk(8'h1C, 32'h0, "R10");

        idle(2);
        finish_run();
    end

endmodule